// File: doc/BRIEF.md
# Periodic Event Timer Channel

This block is an event timer with a register interface. A free-running main counter advances by one on each clock while the general run bit is set. A single comparator channel watches the counter and raises an interrupt when the two are equal. In one-shot mode the comparator stays where it is after it fires. In periodic mode a stored period is added to the comparator each time it fires, so the next event is scheduled automatically.

Software programs the block through a single-cycle write strobe and a combinational read port. The general configuration register also holds a routing flag. Interrupt routing logic outside the block uses this flag to take the channel's interrupt in place of older timer sources. A read-only capability word states that this routing is supported.

A self-clearing sequencing bit in the channel configuration splits comparator writes into two steps. The first write places an absolute target. The second write sets only the period. This lets a periodic timer start while the counter holds any value, not only zero. A 32-bit mode limits both the comparison and the reload arithmetic to the low half of the words.

Top module: `evtmr`

## Requirements
- R1: After reset the general and channel configuration registers read 0, the counter reads 0, the comparator reads all ones, and ch_irq and legacy_route are low.
- R2: Address 0 reads the capability word 0x4001. Bit 0 set means the routing flag is supported, and bits [15:8] hold the counter width (64). Writes to address 0 have no effect.
- R3: Address 1 bit 0 is the run bit. While it is clear, the counter (address 2) holds its value. While it is set, the counter rises by one on every clock. A write to any address takes effect at the rising edge on which wr_en is sampled high.
- R4: Address 1 bit 1 is the routing flag. It reads back and drives legacy_route.
- R5: Address 3 holds the channel configuration: bit 0 enable, bit 1 periodic, bit 2 set-value sequencing, bit 3 32-bit mode. Bit 2 reads as set only while a sequence is pending.
- R6: ch_irq is high during a cycle in which the channel is enabled, the counter is running, and the counter equals the comparator at address 4. A disabled channel never raises ch_irq and never moves its comparator.
- R7: In periodic mode each firing adds the period to the comparator, wrapping modulo 2^64.
- R8: In one-shot mode the comparator keeps its value after firing.
- R9: With bit 2 clear, a comparator write loads both the comparator and the period.
- R10: After bit 2 is written as 1, the next comparator write loads only the comparator. The write after that loads only the period and clears bit 2.
- R11: In 32-bit mode, only the low 32 bits of the counter and comparator are compared. The reload result is the low 32 bits of comparator plus period, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 64 | Combinational read data |
| ch_irq | output | 1 | Channel interrupt, high for each matching cycle |
| legacy_route | output | 1 | Routing flag from the general configuration |

## Verification
The assertions assume that wr_addr and wr_data are defined whenever wr_en is high, and that only one register is written per cycle. The reload check assumes that no comparator write arrives in the cycle it watches. The checks for the two-step sequence assume that the channel configuration is not rewritten between the two comparator writes. The stimulus drives every input on the falling edge and writes the counter and comparator only while the run bit is clear. It starts each interrupt window from a known counter value, so the firing points and the final comparator value can be worked out in advance.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int unsigned TW   = 64;
  localparam int unsigned HW   = TW / 2;
  localparam int unsigned AW   = 3;
  localparam int unsigned CFGW = 4;

  typedef logic [TW-1:0] tword_t;

  typedef enum logic [AW-1:0] {
    RA_CAP  = 3'd0,
    RA_GCFG = 3'd1,
    RA_CNT  = 3'd2,
    RA_CCFG = 3'd3,
    RA_CMP  = 3'd4
  } raddr_e;

  localparam int GC_RUN = 0;
  localparam int GC_LEG = 1;
  localparam int CC_EN  = 0;
  localparam int CC_PER = 1;
  localparam int CC_SET = 2;
  localparam int CC_M32 = 3;

  localparam logic LEG_SUPPORTED = 1'b1;

  // Equality on the full word or on the low half only.
  function automatic logic hits(tword_t cnt, tword_t cmp, logic m32);
    if (m32) return cnt[HW-1:0] == cmp[HW-1:0];
    return cnt == cmp;
  endfunction

  // Next comparator target after a periodic firing.
  function automatic tword_t advance(tword_t cmp, tword_t per, logic m32);
    tword_t s;
    if (m32) begin
      s = '0;
      s[HW-1:0] = cmp[HW-1:0] + per[HW-1:0];
    end else begin
      s = cmp + per;
    end
    return s;
  endfunction

  function automatic tword_t cap_word();
    tword_t w;
    w = '0;
    w[0]    = LEG_SUPPORTED;
    w[15:8] = 8'(TW);
    return w;
  endfunction
endpackage

// File: rtl/evtmr_counter.sv
module evtmr_counter
  import evtmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   ld,
  input  tword_t ld_val,
  output tword_t cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (run) cnt <= cnt + tword_t'(1);
  end
endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
  import evtmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            cmp_wr,
  input  tword_t          cmp_wdata,
  input  tword_t          cnt,
  input  logic            run,
  output logic            en,
  output logic            per_mode,
  output logic            m32,
  output logic            set_pend,
  output logic            set_phase,
  output tword_t          cmp,
  output tword_t          period,
  output logic            fire,
  output logic            reload
);
  logic match;

  assign match  = hits(cnt, cmp, m32);
  assign fire   = en && run && match;
  assign reload = fire && per_mode;

  // Plain configuration bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      per_mode <= 1'b0;
      m32      <= 1'b0;
    end else if (cfg_wr) begin
      en       <= cfg_wdata[CC_EN];
      per_mode <= cfg_wdata[CC_PER];
      m32      <= cfg_wdata[CC_M32];
    end
  end

  // Two-step comparator write sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_pend  <= 1'b0;
      set_phase <= 1'b0;
    end else if (cfg_wr) begin
      set_pend  <= cfg_wdata[CC_SET];
      set_phase <= 1'b0;
    end else if (cmp_wr && set_pend) begin
      if (!set_phase) begin
        set_phase <= 1'b1;
      end else begin
        set_phase <= 1'b0;
        set_pend  <= 1'b0;
      end
    end
  end

  // Comparator and period; a register write outranks a reload
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp    <= '1;
      period <= '0;
    end else if (cmp_wr) begin
      if (!set_pend) begin
        cmp    <= cmp_wdata;
        period <= cmp_wdata;
      end else if (!set_phase) begin
        cmp    <= cmp_wdata;
      end else begin
        period <= cmp_wdata;
      end
    end else if (reload) begin
      cmp <= advance(cmp, period, m32);
    end
  end
endmodule

// File: rtl/evtmr_rdmux.sv
module evtmr_rdmux
  import evtmr_pkg::*;
(
  input  logic [AW-1:0] rd_addr,
  input  tword_t        cap,
  input  tword_t        gcfg,
  input  tword_t        cnt,
  input  tword_t        ccfg,
  input  tword_t        cmp,
  output tword_t        rd_data
);
  always_comb begin
    case (rd_addr)
      RA_CAP:  rd_data = cap;
      RA_GCFG: rd_data = gcfg;
      RA_CNT:  rd_data = cnt;
      RA_CCFG: rd_data = ccfg;
      RA_CMP:  rd_data = cmp;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/evtmr.sv
module evtmr
  import evtmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [TW-1:0] rd_data,
  output logic          ch_irq,
  output logic          legacy_route
);
  logic   run_q, leg_q;
  logic   wr_gcfg, wr_cnt, wr_ccfg, wr_cmp;
  logic   ch_en, ch_per, ch_m32, ch_set, set_phase, fire, reload;
  tword_t cnt_q, cmp_q, per_q;
  tword_t gcfg_word, ccfg_word;

  assign wr_gcfg = wr_en && (wr_addr == RA_GCFG);
  assign wr_cnt  = wr_en && (wr_addr == RA_CNT);
  assign wr_ccfg = wr_en && (wr_addr == RA_CCFG);
  assign wr_cmp  = wr_en && (wr_addr == RA_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_gcfg) begin
      run_q <= wr_data[GC_RUN];
      leg_q <= wr_data[GC_LEG];
    end
  end

  evtmr_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .ld     (wr_cnt),
    .ld_val (wr_data),
    .cnt    (cnt_q)
  );

  evtmr_channel u_ch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (wr_ccfg),
    .cfg_wdata (wr_data[CFGW-1:0]),
    .cmp_wr    (wr_cmp),
    .cmp_wdata (wr_data),
    .cnt       (cnt_q),
    .run       (run_q),
    .en        (ch_en),
    .per_mode  (ch_per),
    .m32       (ch_m32),
    .set_pend  (ch_set),
    .set_phase (set_phase),
    .cmp       (cmp_q),
    .period    (per_q),
    .fire      (fire),
    .reload    (reload)
  );

  always_comb begin
    gcfg_word         = '0;
    gcfg_word[GC_RUN] = run_q;
    gcfg_word[GC_LEG] = leg_q;
    ccfg_word         = '0;
    ccfg_word[CC_EN]  = ch_en;
    ccfg_word[CC_PER] = ch_per;
    ccfg_word[CC_SET] = ch_set;
    ccfg_word[CC_M32] = ch_m32;
  end

  evtmr_rdmux u_rd (
    .rd_addr (rd_addr),
    .cap     (cap_word()),
    .gcfg    (gcfg_word),
    .cnt     (cnt_q),
    .ccfg    (ccfg_word),
    .cmp     (cmp_q),
    .rd_data (rd_data)
  );

  assign ch_irq       = fire;
  assign legacy_route = leg_q;
endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk
  import evtmr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input tword_t        wr_data,
  input logic [AW-1:0] rd_addr,
  input tword_t        rd_data,
  input tword_t        cnt,
  input tword_t        cmp,
  input tword_t        per,
  input logic          run,
  input logic          ch_en,
  input logic          ch_per,
  input logic          ch_m32,
  input logic          ch_set,
  input logic          set_phase,
  input logic          reload,
  input logic          ch_irq
);
  logic cnt_wr, cmp_wr;
  assign cnt_wr = wr_en && (wr_addr == RA_CNT);
  assign cmp_wr = wr_en && (wr_addr == RA_CMP);

  a_r2_cap_const: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == RA_CAP) |-> (rd_data == 64'h0000_0000_0000_4001));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1));

  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !ch_irq);

  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !ch_m32 && !cmp_wr) |=> (cmp == $past(cmp) + $past(per)));

  a_r8_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq && !ch_per && !cmp_wr) |=> $stable(cmp));

  a_r10_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && ch_set && !set_phase) |=> ($stable(per) && cmp == $past(wr_data)));

  a_r10_second: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && ch_set && set_phase) |=> (!ch_set && $stable(cmp)));
endmodule

bind evtmr evtmr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .cnt       (cnt_q),
  .cmp       (cmp_q),
  .per       (per_q),
  .run       (run_q),
  .ch_en     (ch_en),
  .ch_per    (ch_per),
  .ch_m32    (ch_m32),
  .ch_set    (ch_set),
  .set_phase (set_phase),
  .reload    (reload),
  .ch_irq    (ch_irq)
);

// File: tb/evtmr_test.sv
module evtmr_test;
  import evtmr_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        ch_irq;
  logic        legacy_route;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  evtmr uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch_irq(ch_irq), .legacy_route(legacy_route)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && ch_irq) irq_seen++;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard monitor: compares the read port with each queued expectation
  initial begin
    forever begin
      item_t cur;
      wait (sb.size() != 0);
      cur = sb[0];
      #1;
      check(rd_data, cur.exp, cur.tag);
      sb.delete(0);
    end
  end

  task automatic expect_rd(input logic [2:0] a, input logic [63:0] e, input string tag);
    rd_addr = a;
    sb.push_back('{exp: e, tag: tag});
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counter advances exactly n times; values n-1 above the start are seen running
  task automatic run_for(input int n);
    irq_seen = 0;
    wr(RA_GCFG, 64'd1);
    repeat (n - 2) @(negedge clk);
    wr(RA_GCFG, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd(RA_GCFG, 64'd0, "R1 gcfg");
    expect_rd(RA_CNT, 64'd0, "R1 counter");
    expect_rd(RA_CCFG, 64'd0, "R1 ccfg");
    expect_rd(RA_CMP, '1, "R1 comparator");
    check(ch_irq, 1'b0, "R1 irq");
    check(legacy_route, 1'b0, "R1 legacy_route");

    // R2 capability, write ignored
    expect_rd(RA_CAP, 64'h4001, "R2 capability");
    wr(RA_CAP, 64'h0);
    expect_rd(RA_CAP, 64'h4001, "R2 capability after write");

    // R3 hold while stopped, then count
    repeat (10) @(negedge clk);
    expect_rd(RA_CNT, 64'd0, "R3 counter held");
    wr(RA_CNT, 64'd100);
    expect_rd(RA_CNT, 64'd100, "R3 counter load");
    run_for(21);
    expect_rd(RA_CNT, 64'd121, "R3 counter advance");

    // R4 routing flag
    wr(RA_GCFG, 64'd2);
    check(legacy_route, 1'b1, "R4 legacy_route set");
    expect_rd(RA_GCFG, 64'd2, "R4 gcfg readback");
    wr(RA_GCFG, 64'd0);
    check(legacy_route, 1'b0, "R4 legacy_route clear");

    // R10 two-step write, periodic R7
    wr(RA_CNT, 64'd1000);
    wr(RA_CCFG, 64'h7);
    expect_rd(RA_CCFG, 64'h7, "R5 ccfg set-value pending");
    wr(RA_CMP, 64'd1010);
    expect_rd(RA_CMP, 64'd1010, "R10 first write to comparator");
    expect_rd(RA_CCFG, 64'h7, "R10 still pending after first");
    wr(RA_CMP, 64'd7);
    expect_rd(RA_CMP, 64'd1010, "R10 second write leaves comparator");
    expect_rd(RA_CCFG, 64'h3, "R10 set-value self-cleared");
    run_for(30);
    check(irq_seen, 3, "R7 periodic firings");
    expect_rd(RA_CMP, 64'd1031, "R7 comparator after reloads");
    expect_rd(RA_CNT, 64'd1030, "R3 counter after periodic run");

    // R9 single write loads both
    wr(RA_CMP, 64'd1040);
    run_for(20);
    check(irq_seen, 1, "R9 firing count");
    expect_rd(RA_CMP, 64'd2080, "R9 period also loaded");

    // R8 one-shot
    wr(RA_CCFG, 64'h1);
    wr(RA_CMP, 64'd1060);
    run_for(15);
    check(irq_seen, 1, "R8 one-shot fires once");
    expect_rd(RA_CMP, 64'd1060, "R8 comparator kept");

    // R6 disabled channel
    wr(RA_CCFG, 64'h2);
    wr(RA_CMP, 64'd1070);
    run_for(10);
    check(irq_seen, 0, "R6 disabled never fires");
    expect_rd(RA_CMP, 64'd1070, "R6 disabled comparator unchanged");

    // R11 32-bit mode, upper halves differ
    wr(RA_CNT, 64'h0000_0005_FFFF_FFF0);
    wr(RA_CCFG, 64'hF);
    wr(RA_CMP, 64'h0000_0000_FFFF_FFF8);
    wr(RA_CMP, 64'd16);
    expect_rd(RA_CCFG, 64'hB, "R5 ccfg 32-bit periodic");
    run_for(20);
    check(irq_seen, 1, "R11 low-half match fires");
    expect_rd(RA_CMP, 64'h8, "R11 reload wraps in 32 bits");
    expect_rd(RA_CNT, 64'h0000_0006_0000_0004, "R11 counter stays 64-bit");

    // R7 64-bit wrap of the reload
    wr(RA_CNT, 64'hFFFF_FFFF_FFFF_FFE8);
    wr(RA_CCFG, 64'h7);
    wr(RA_CMP, 64'hFFFF_FFFF_FFFF_FFF0);
    wr(RA_CMP, 64'h20);
    run_for(10);
    check(irq_seen, 1, "R7 firing near wrap");
    expect_rd(RA_CMP, 64'h10, "R7 reload wraps modulo 2^64");
    check(ch_irq, 1'b0, "R6 irq low when stopped");

    report();
  end
endmodule